// File: doc/BRIEF.md
# Firmware Image Byte Scrambler

This block turns a plain firmware image into its scrambled on-disk layout, or turns a scrambled image back into plain order. A run begins with a start pulse carrying the direction and the image length in bytes. The block then takes in exactly that many in-range byte writes, each tagged with an address. Every byte is bit-transformed on the way into an internal byte buffer. Once the buffer is full, the block streams the image out over a valid/ready channel.

In the scrambling direction, bytes are spread over four equal segments chosen by the low two address bits, and the stream is preceded by six header bytes taken from an input bus. In the restoring direction, the input positions are the scrambled positions. The stream leaves in plain address order with no header, and the upstream logic is expected to have stripped the header already. A one-cycle done pulse marks the end of each run. Flags report a refused length and dropped out-of-range writes.

Top module: `fw_scrambler`

## Requirements
- R1: In scramble mode (descMode=0) each stored byte d leaves as the bitwise inverse of d rotated left by one bit, i.e. {~d[6:0], ~d[7]}.
- R2: In scramble mode, with image length L, the byte written at plain address a leaves at image position (a mod 4)*(L/4) + (a div 4).
- R3: In scramble mode, six header bytes leave before any image byte: hdrBytes[7:0] first, then hdrBytes[15:8], and so on to hdrBytes[47:40].
- R4: In descramble mode (descMode=1) no header is sent. The byte written at scrambled position p leaves at plain position (p mod L/4)*4 + (p div L/4), with the value ~{d[0], d[7:1]} (rotated right by one, then inverted).
- R5: A start while idle with a length that is zero, not a multiple of four, or above DEPTH sets lenErr in the next cycle and leaves the block idle (inReady low). An accepted start clears lenErr.
- R6: During loading, a write whose address is at or above L is dropped and sets ovfErr, which stays set until the next accepted start. Loading still ends only after L in-range writes.
- R7: While outValid is high and outReady is low, outValid stays high and outData does not change.
- R8: done is high for exactly one cycle, the cycle after the last image byte is accepted. The block is idle in that cycle and accepts a start given in it.
- R9: inReady is high only while loading, and outValid only while streaming; the two are never high together. A start given while not idle is ignored.
- R10: After reset, inReady, outValid, done, lenErr and ovfErr are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| descMode | input | 1 | 0 = scramble, 1 = descramble; sampled with start |
| imgLen | input | $clog2(DEPTH+1) | Image length in bytes; sampled with start |
| hdrBytes | input | 48 | Six header bytes, lowest byte sent first |
| inValid | input | 1 | Input byte present |
| inAddr | input | $clog2(DEPTH+1) | Address of the input byte |
| inData | input | 8 | Input byte |
| inReady | output | 1 | Block is loading and takes input bytes |
| outValid | output | 1 | Output byte present |
| outReady | input | 1 | Sink accepts the output byte |
| outData | output | 8 | Output byte |
| done | output | 1 | One-cycle pulse after the final output byte |
| lenErr | output | 1 | Last start was refused for its length |
| ovfErr | output | 1 | An out-of-range write was dropped in this run |

## Verification
Two events can fall in the same cycle: the end-of-run done pulse, and a fresh start that the block accepts because it is already idle again. The bench raises start in exactly the cycle where it sees done high, with the opposite direction and a new length. It judges the overlap by checking that loading begins one cycle later and that the following run streams the correct bytes. A second overlap is also tested: a start presented in the middle of loading, together with a write. Here the pass condition is that the first run's output is untouched.

// File: rtl/fw_scr_pkg.sv
package fw_scr_pkg;

  // Number of header bytes placed ahead of a scrambled image.
  localparam int HDR_BYTES = 6;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOAD,
    PH_HDR,
    PH_IMG
  } phase_t;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic bufWrite;  // commit transformed byte to the buffer
    logic showHdr;   // output mux selects a header byte
    logic descMode;  // latched direction of the current run
  } strobe_t;

endpackage

// File: rtl/fw_scr_ctrl.sv
module fw_scr_ctrl
  import fw_scr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             descIn,
  input  logic [LEN_W-1:0] imgLen,
  input  logic             inValid,
  input  logic [LEN_W-1:0] inAddr,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             done,
  output logic             lenErr,
  output logic             ovfErr,
  output strobe_t          stb,
  output logic [2:0]       hdrIdx,
  output logic [LEN_W-1:0] imgIdx,
  output logic [LEN_W-1:0] lenReg
);

  localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(DEPTH);
  localparam logic [2:0]       HDR_LAST = 3'(HDR_BYTES - 1);

  phase_t           phase;
  logic             descReg;
  logic [LEN_W-1:0] wrCnt;
  logic             lenBad;
  logic             inFire;
  logic             inRange;
  logic [LEN_W-1:0] lenLast;

  assign lenBad  = (imgLen[1:0] != 2'b00) || (imgLen == '0) || (imgLen > MAX_LEN);
  assign inFire  = (phase == PH_LOAD) && inValid;
  assign inRange = inAddr < lenReg;
  assign lenLast = lenReg - LEN_W'(1);

  assign inReady  = (phase == PH_LOAD);
  assign outValid = (phase == PH_HDR) || (phase == PH_IMG);

  always_comb begin
    stb.bufWrite = inFire && inRange;
    stb.showHdr  = (phase == PH_HDR);
    stb.descMode = descReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      descReg <= 1'b0;
      lenReg  <= '0;
      wrCnt   <= '0;
      imgIdx  <= '0;
      hdrIdx  <= '0;
      done    <= 1'b0;
      lenErr  <= 1'b0;
      ovfErr  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            if (lenBad) begin
              lenErr <= 1'b1;
            end else begin
              lenErr  <= 1'b0;
              ovfErr  <= 1'b0;
              lenReg  <= imgLen;
              descReg <= descIn;
              wrCnt   <= '0;
              phase   <= PH_LOAD;
            end
          end
        end
        PH_LOAD: begin
          if (inFire) begin
            if (!inRange) begin
              ovfErr <= 1'b1;
            end else begin
              wrCnt <= wrCnt + LEN_W'(1);
              if (wrCnt == lenLast) begin
                hdrIdx <= '0;
                imgIdx <= '0;
                phase  <= descReg ? PH_IMG : PH_HDR;
              end
            end
          end
        end
        PH_HDR: begin
          if (outReady) begin
            hdrIdx <= hdrIdx + 3'd1;
            if (hdrIdx == HDR_LAST) phase <= PH_IMG;
          end
        end
        PH_IMG: begin
          if (outReady) begin
            imgIdx <= imgIdx + LEN_W'(1);
            if (imgIdx == lenLast) begin
              phase <= PH_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fw_scr_datapath.sv
module fw_scr_datapath
  import fw_scr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LEN_W = 7
) (
  input  logic                     clk,
  input  strobe_t                  stb,
  input  logic [LEN_W-1:0]         inAddr,
  input  logic [7:0]               inData,
  input  logic [8*HDR_BYTES-1:0]   hdrBytes,
  input  logic [2:0]               hdrIdx,
  input  logic [LEN_W-1:0]         imgIdx,
  input  logic [LEN_W-1:0]         lenReg,
  output logic [7:0]               outData
);

  // Position inside the segmented layout: seg*(L/4) + off.
  function automatic logic [LEN_W-1:0] segPos(
    input logic [1:0]       seg,
    input logic [LEN_W-1:0] off,
    input logic [LEN_W-1:0] quarter
  );
    logic [LEN_W-1:0] base;
    unique case (seg)
      2'd0:    base = '0;
      2'd1:    base = quarter;
      2'd2:    base = quarter << 1;
      default: base = quarter + (quarter << 1);
    endcase
    return base + off;
  endfunction

  logic [LEN_W-1:0] quarter;
  logic [LEN_W-1:0] wrPos;
  logic [LEN_W-1:0] rdPos;
  logic [7:0]       wrByte;
  logic [7:0]       rdByte;
  logic [7:0]       hdrByte;
  logic [7:0]       bank [DEPTH];

  assign quarter = lenReg >> 2;

  // Scramble spreads on the way in; descramble gathers on the way out.
  assign wrPos = stb.descMode ? inAddr : segPos(inAddr[1:0], inAddr >> 2, quarter);
  assign rdPos = stb.descMode ? segPos(imgIdx[1:0], imgIdx >> 2, quarter) : imgIdx;

  assign wrByte = stb.descMode ? ~{inData[0], inData[7:1]}
                               : {~inData[6:0], ~inData[7]};

  for (genvar i = 0; i < DEPTH; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (stb.bufWrite && (wrPos == LEN_W'(i))) bank[i] <= wrByte;
    end
  end

  always_comb begin
    rdByte = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdPos == LEN_W'(i)) rdByte = bank[i];
    end
  end

  always_comb begin
    hdrByte = '0;
    for (int h = 0; h < HDR_BYTES; h++) begin
      if (hdrIdx == 3'(h)) hdrByte = hdrBytes[8*h +: 8];
    end
  end

  assign outData = stb.showHdr ? hdrByte : rdByte;

endmodule

// File: rtl/fw_scrambler.sv
module fw_scrambler
  import fw_scr_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   descMode,
  input  logic [LEN_W-1:0]       imgLen,
  input  logic [8*HDR_BYTES-1:0] hdrBytes,
  input  logic                   inValid,
  input  logic [LEN_W-1:0]       inAddr,
  input  logic [7:0]             inData,
  output logic                   inReady,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [7:0]             outData,
  output logic                   done,
  output logic                   lenErr,
  output logic                   ovfErr
);

  strobe_t          stb;
  logic [2:0]       hdrIdx;
  logic [LEN_W-1:0] imgIdx;
  logic [LEN_W-1:0] lenReg;

  fw_scr_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .descIn(descMode), .imgLen(imgLen),
    .inValid(inValid), .inAddr(inAddr), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .done(done),
    .lenErr(lenErr), .ovfErr(ovfErr), .stb(stb),
    .hdrIdx(hdrIdx), .imgIdx(imgIdx), .lenReg(lenReg)
  );

  fw_scr_datapath #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .stb(stb), .inAddr(inAddr), .inData(inData),
    .hdrBytes(hdrBytes), .hdrIdx(hdrIdx), .imgIdx(imgIdx),
    .lenReg(lenReg), .outData(outData)
  );

endmodule

// File: rtl/fw_scrambler_chk.sv
module fw_scrambler_chk #(
  parameter  int DEPTH = 64,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [LEN_W-1:0] imgLen,
  input logic             inReady,
  input logic             inValid,
  input logic             outValid,
  input logic             outReady,
  input logic [7:0]       outData,
  input logic             done,
  input logic             lenErr,
  input logic             ovfErr
);

  // R5
  len_refuse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !inReady && !outValid && imgLen[1:0] != 2'b00) |=> (lenErr && !inReady));

  // R6
  ovf_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfErr) |-> $past(inReady && inValid));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(outValid && outReady) && !outValid && !inReady));

  // R9
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

endmodule

bind fw_scrambler fw_scrambler_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .imgLen(imgLen),
  .inReady(inReady), .inValid(inValid), .outValid(outValid),
  .outReady(outReady), .outData(outData), .done(done),
  .lenErr(lenErr), .ovfErr(ovfErr)
);

// File: tb/fw_scrambler_tb.sv
module fw_scrambler_tb;

  localparam int DEPTH = 64;
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam logic [47:0] HDR = 48'h665544332211;
  // {desc[31], stall[30], reverse[29], len[22:16], seed[7:0]}
  localparam logic [31:0] VEC [7] = '{
    32'h0008_0011, 32'h6040_005A, 32'h0004_00F0, 32'h8008_0003,
    32'hE040_0081, 32'h800C_007E, 32'h400C_0033
  };

  logic clk = 0;
  logic rstN = 0;
  logic start = 0, descMode = 0, inValid = 0, outReady = 0;
  logic [LEN_W-1:0] imgLen = '0, inAddr = '0;
  logic [7:0] inData = '0;
  logic [47:0] hdrBytes = HDR;
  logic inReady, outValid, done, lenErr, ovfErr;
  logic [7:0] outData;

  int checks = 0, errors = 0, cyc = 0, total = 0;
  logic [7:0] expq [70];
  logic [7:0] fixed [4];
  bit useFixed = 0;

  always #5 clk = ~clk;

  fw_scrambler #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .descMode(descMode), .imgLen(imgLen),
    .hdrBytes(hdrBytes), .inValid(inValid), .inAddr(inAddr), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outReady(outReady), .outData(outData),
    .done(done), .lenErr(lenErr), .ovfErr(ovfErr)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dgen(int seed, int i);
    if (useFixed) return fixed[i];
    return 8'((i * 37) + (seed * 11) + (i >> 1));
  endfunction

  function automatic logic [7:0] scrModel(logic [7:0] d);
    logic [7:0] n = ~d;
    return 8'((n << 1) | (n >> 7));
  endfunction

  function automatic logic [7:0] descModel(logic [7:0] d);
    return ~(8'((d >> 1) | (d << 7)));
  endfunction

  task automatic buildExp(bit m, int L, int seed);
    int q = L / 4;
    if (!m) begin
      for (int h = 0; h < 6; h++) expq[h] = HDR[8*h +: 8];
      for (int a = 0; a < L; a++) expq[6 + (a % 4) * q + a / 4] = scrModel(dgen(seed, a));
      total = L + 6;
    end else begin
      for (int p = 0; p < L; p++) expq[(p % q) * 4 + p / q] = descModel(dgen(seed, p));
      total = L;
    end
  endtask

  task automatic doStart(bit m, int L);
    descMode = m; imgLen = LEN_W'(L); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic doLoad(bit m, int L, int seed, bit rev, int dropAt, bit busyStart);
    for (int j = 0; j < L; j++) begin
      int a = rev ? (L - 1 - j) : j;
      if (j == dropAt) begin
        inValid = 1; inAddr = LEN_W'(L + 1); inData = 8'hEE;
        @(negedge clk);
        chk(ovfErr == 1'b1, "R6 drop flag", ovfErr, 1);
      end
      inValid = 1; inAddr = LEN_W'(a); inData = dgen(seed, a);
      if (busyStart && j == 1) begin start = 1; imgLen = LEN_W'(4); descMode = ~m; end
      @(negedge clk);
      start = 0;
    end
    inValid = 0;
  endtask

  task automatic doCollect(bit stall, string req);
    int k = 0;
    bit prevStall = 0;
    logic [7:0] prevData = '0;
    while (k < total) begin
      bit rdy;
      if (prevStall) chk(outValid && outData == prevData, "R7 hold", outData, prevData);
      if (inReady && outValid) chk(0, "R9 exclusive", 1, 0);
      rdy = stall ? (cyc % 3 != 0) : 1'b1;
      outReady = rdy;
      if (outValid && rdy) begin
        chk(outData == expq[k], (!useFixed && k < 6 && req == "R2") ? "R3 header" : req, outData, expq[k]);
        k++;
      end
      prevStall = outValid && !rdy;
      prevData = outData;
      @(negedge clk);
    end
    outReady = 0;
    chk(done == 1'b1 && !outValid && !inReady, "R8 done pulse", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({inReady, outValid, done, lenErr, ovfErr} == 5'b0, "R10 in reset", 1, 0);
    rstN = 1;
    @(negedge clk);
    chk({inReady, outValid, done, lenErr, ovfErr} == 5'b0, "R10 after reset", 1, 0);

    // Vector table walk
    for (int v = 0; v < 7; v++) begin
      bit m = VEC[v][31], st = VEC[v][30], rv = VEC[v][29];
      int L = int'(VEC[v][22:16]);
      int sd = int'(VEC[v][7:0]);
      doStart(m, L);
      chk(inReady && !lenErr, "R9 load entered", inReady, 1);
      doLoad(m, L, sd, rv, -1, 0);
      buildExp(m, L, sd);
      doCollect(st, m ? "R4" : "R2");
      @(negedge clk);
      chk(!done, "R8 one cycle", done, 0);
    end

    // R1: fixed bytes, length 4 places byte a at position a
    useFixed = 1;
    fixed[0] = 8'h00; fixed[1] = 8'h80; fixed[2] = 8'h01; fixed[3] = 8'hA5;
    doStart(0, 4);
    doLoad(0, 4, 0, 0, -1, 0);
    for (int h = 0; h < 6; h++) expq[h] = HDR[8*h +: 8];
    expq[6] = 8'hFF; expq[7] = 8'hFE; expq[8] = 8'hFD; expq[9] = 8'hB4;
    total = 10;
    doCollect(0, "R1");
    useFixed = 0;

    // R5: refused lengths
    doStart(0, 6);
    chk(lenErr && !inReady, "R5 len 6", lenErr, 1);
    doStart(0, 0);
    chk(lenErr && !inReady, "R5 len 0", lenErr, 1);
    doStart(1, 68);
    chk(lenErr && !inReady, "R5 len 68", lenErr, 1);

    // R6 + R9: dropped write and ignored start during load
    doStart(0, 8);
    chk(!lenErr && inReady, "R5 cleared", lenErr, 0);
    doLoad(0, 8, 9, 0, 3, 1);
    buildExp(0, 8, 9);
    doCollect(0, "R6 dropped write kept image");
    chk(ovfErr == 1'b1, "R6 sticky", ovfErr, 1);

    // R8: start in the done cycle
    doStart(0, 8);
    chk(!ovfErr, "R6 cleared by start", ovfErr, 0);
    doLoad(0, 8, 4, 1, -1, 0);
    buildExp(0, 8, 4);
    doCollect(1, "R2");
    doStart(1, 4);
    chk(inReady, "R8 start in done cycle", inReady, 1);
    doLoad(1, 4, 21, 0, -1, 0);
    buildExp(1, 4, 21);
    doCollect(0, "R8 chained run");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule